// File: doc/BRIEF.md
# Logical-test instruction byte decoder

This block turns a stream of instruction bytes into one decoded record for the bitwise-AND-and-set-flags comparison family of a variable-length instruction set. Bytes arrive one per cycle on a valid/ready handshake. The stream starts with any number of prefix bytes: the operand-size override, the bus-lock prefix, and the register-extension prefix byte (0x40 to 0x4F). One opcode byte follows. Depending on the opcode, a register/memory selector byte (ModRM) and up to four little-endian immediate bytes come after it.

When the last byte of an instruction has been accepted, the decoder presents a record for exactly one cycle. The record gives the operand width, the operand form and both register indices with their high-byte flags. It also gives a flag for a memory operand, the immediate widened to 64 bits, an invalid-opcode fault flag and a not-this-instruction flag. Address generation and execution happen downstream. A memory operand is only flagged here: no displacement or index byte is parsed. The decoder then returns to waiting for prefixes, with every prefix cleared.

Top module: `andtest_decode`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The bytes 0x66, 0xF0 and 0x40..0x4F are prefixes and may come in any order and number before the opcode. In an extension prefix, bit 3 is W, bit 2 extends the reg field and bit 0 extends the rm field.
- R3: Opcode 0xA8 decodes as form 0 (accumulator-immediate) at size 8 with one immediate byte. Opcode 0xA9 decodes as form 0 at the wide size. Both give register index 0, no ModRM byte and out_rm_mem 0.
- R4: out_size codes are 0=8, 1=16, 2=32 and 3=64 bits. Opcodes 0xA8, 0xF6 and 0x84 are always code 0. Opcodes 0xA9, 0xF7 and 0x85 give code 3 when W is set, otherwise code 1 when 0x66 was seen, otherwise code 2.
- R5: The number of immediate bytes is 1 for size 8, 2 for size 16 and 4 for sizes 32 and 64. The bytes are taken least significant first.
- R6: out_imm is the immediate zero-extended for sizes 8, 16 and 32, and sign-extended from bit 31 for size 64.
- R7: Opcodes 0xF6 and 0xF7 read a ModRM byte (mod bits 7:6, reg bits 5:3, rm bits 2:0). A reg field of 0 or 1 gives form 1 (r/m-immediate), with out_reg_idx 0 and out_reg_hi 0.
- R8: On 0xF6 or 0xF7, a reg field of 2 to 7 ends the instruction right after the ModRM byte with out_not_test 1. No immediate byte is consumed.
- R9: Opcodes 0x84 and 0x85 give form 2 (r/m-register) with no immediate: out_imm is 0 and out_reg_idx is {reg-extension bit, reg field}.
- R10: A mod field other than 3 sets out_rm_mem. out_rm_idx is then {rm-extension bit, rm field} and out_rm_hi is 0.
- R11: For a size-8 register operand with no extension prefix, field values 4..7 give index 0..3 with the matching hi flag set. With any extension prefix, the index is {extension bit, field} and the hi flag is 0.
- R12: A 0xF0 prefix on a recognised opcode still yields the complete record, with out_fault_ud 1. Without that prefix, out_fault_ud is 0.
- R13: Any other opcode byte ends the instruction at once with out_not_test 1 and out_fault_ud 0.
- R14: out_valid is high for exactly one cycle, in the cycle after the last byte is accepted. in_ready is 0 in that cycle. A byte offered during that cycle is not taken, and the next instruction starts with all prefixes cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| out_valid | output | 1 | One-cycle record strobe |
| out_size | output | 2 | Operand size code |
| out_form | output | 2 | Operand form code |
| out_rm_idx | output | 4 | First operand register index |
| out_rm_hi | output | 1 | First operand is a legacy high byte |
| out_rm_mem | output | 1 | First operand is in memory |
| out_reg_idx | output | 4 | Second operand register index |
| out_reg_hi | output | 1 | Second operand is a legacy high byte |
| out_imm | output | 64 | Widened immediate |
| out_fault_ud | output | 1 | Invalid-opcode fault from the lock prefix |
| out_not_test | output | 1 | Byte stream is not this instruction family |

## Verification
The sweeps go after several corner cases, each with a visible failure.

- **High-byte mapping.** The bench runs every ModRM value under several extension-prefix values. A decoder that ignored the prefix when mapping byte registers would report the hi flag and a shifted index for encodings 4 to 7.
- **Width combinations.** Combining the size override with W catches a decoder that let 0x66 win over W. Such a decoder would also fetch two immediate bytes instead of four and misalign every byte after it.
- **Sign extension.** Immediates with bit 31 set separate correct sign extension from zero extension at size 64.
- **Stray bytes.** The reg-field sweep on 0xF6 and 0xF7, the full opcode sweep and a byte offered during the record cycle all check the same thing. A decoder that swallowed a stray byte, or carried a prefix into the next instruction, would raise a wrong fault or report the wrong size.

// File: rtl/andtest_pkg.sv
package andtest_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        FORM_ACC_IMM = 2'd0,
        FORM_RM_IMM  = 2'd1,
        FORM_RM_REG  = 2'd2,
        FORM_NONE    = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ST_PFX   = 2'd0,
        ST_MODRM = 2'd1,
        ST_IMM   = 2'd2,
        ST_EMIT  = 2'd3
    } state_e;

    typedef struct packed {
        logic lock;
        logic osz16;
        logic rex_seen;
        logic w;
        logic r;
        logic b;
    } pfx_t;

    typedef struct packed {
        logic  known;
        form_e form;
        logic  byte_op;
        logic  has_modrm;
    } opinfo_t;

    localparam logic [7:0] BYTE_OSZ   = 8'h66;
    localparam logic [7:0] BYTE_LOCK  = 8'hF0;
    localparam logic [3:0] REX_HIGH   = 4'h4;
    localparam logic [7:0] OPC_ACC8   = 8'hA8;
    localparam logic [7:0] OPC_ACCW   = 8'hA9;
    localparam logic [7:0] OPC_RMI8   = 8'hF6;
    localparam logic [7:0] OPC_RMIW   = 8'hF7;
    localparam logic [7:0] OPC_RMR8   = 8'h84;
    localparam logic [7:0] OPC_RMRW   = 8'h85;

    function automatic logic is_prefix(input logic [7:0] b);
        return (b == BYTE_OSZ) || (b == BYTE_LOCK) || (b[7:4] == REX_HIGH);
    endfunction

    function automatic opinfo_t classify(input logic [7:0] b);
        opinfo_t o;
        o = '{known: 1'b1, form: FORM_NONE, byte_op: 1'b0, has_modrm: 1'b0};
        case (b)
            OPC_ACC8: begin o.form = FORM_ACC_IMM; o.byte_op = 1'b1; end
            OPC_ACCW: begin o.form = FORM_ACC_IMM; end
            OPC_RMI8: begin o.form = FORM_RM_IMM; o.byte_op = 1'b1; o.has_modrm = 1'b1; end
            OPC_RMIW: begin o.form = FORM_RM_IMM; o.has_modrm = 1'b1; end
            OPC_RMR8: begin o.form = FORM_RM_REG; o.byte_op = 1'b1; o.has_modrm = 1'b1; end
            OPC_RMRW: begin o.form = FORM_RM_REG; o.has_modrm = 1'b1; end
            default:  o.known = 1'b0;
        endcase
        return o;
    endfunction

    function automatic opsize_e pick_size(input logic byte_op, input pfx_t p);
        if (byte_op)      return SZ_8;
        else if (p.w)     return SZ_64;
        else if (p.osz16) return SZ_16;
        else              return SZ_32;
    endfunction

    function automatic logic [2:0] imm_len(input form_e f, input opsize_e s);
        if (f == FORM_RM_REG || f == FORM_NONE) return 3'd0;
        case (s)
            SZ_8:    return 3'd1;
            SZ_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [63:0] widen_imm(input logic [31:0] v, input opsize_e s);
        if (s == SZ_64) return {{32{v[31]}}, v};
        else            return {32'd0, v};
    endfunction

endpackage

// File: rtl/atd_prefix_acc.sv
module atd_prefix_acc
    import andtest_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       load,
    input  logic [7:0] data,
    output pfx_t       pfx
);
    pfx_t pfx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pfx_q <= '0;
        end else if (load) begin
            if (data == BYTE_OSZ)  pfx_q.osz16 <= 1'b1;
            if (data == BYTE_LOCK) pfx_q.lock  <= 1'b1;
            if (data[7:4] == REX_HIGH) begin
                pfx_q.rex_seen <= 1'b1;
                pfx_q.w        <= data[3];
                pfx_q.r        <= data[2];
                pfx_q.b        <= data[0];
            end
        end
    end

    assign pfx = pfx_q;
endmodule

// File: rtl/atd_reg_map.sv
module atd_reg_map #(
    parameter int FIELD_W = 3,
    localparam int IDX_W  = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               ext,
    input  logic               rex_seen,
    input  logic               byte_op,
    input  logic               is_reg,
    output logic [IDX_W-1:0]   idx,
    output logic               hi
);
    always_comb begin
        if (byte_op && is_reg && !rex_seen && field[FIELD_W-1]) begin
            hi  = 1'b1;
            idx = IDX_W'(field[FIELD_W-2:0]);
        end else begin
            hi  = 1'b0;
            idx = {ext, field};
        end
    end
endmodule

// File: rtl/atd_imm_gather.sv
module atd_imm_gather #(
    parameter int IMM_BYTES = 4,
    localparam int SEL_W    = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1,
    localparam int VAL_W    = 8 * IMM_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       data,
    output logic [VAL_W-1:0] value
);
    for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                lane_q <= '0;
            end else if (load && sel == SEL_W'(g)) begin
                lane_q <= data;
            end
        end
        assign value[8*g +: 8] = lane_q;
    end
endmodule

// File: rtl/andtest_decode.sv
module andtest_decode
    import andtest_pkg::*;
#(
    parameter int IMM_BYTES = 4,
    parameter int FIELD_W   = 3,
    localparam int IDX_W    = FIELD_W + 1,
    localparam int SEL_W    = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1,
    localparam int CNT_W    = $clog2(IMM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [1:0]       out_size,
    output logic [1:0]       out_form,
    output logic [IDX_W-1:0] out_rm_idx,
    output logic             out_rm_hi,
    output logic             out_rm_mem,
    output logic [IDX_W-1:0] out_reg_idx,
    output logic             out_reg_hi,
    output logic [63:0]      out_imm,
    output logic             out_fault_ud,
    output logic             out_not_test
);
    state_e             st_q;
    opinfo_t            info_q;
    logic [7:0]         modrm_q;
    logic               nt_q;
    logic [CNT_W-1:0]   len_q;
    logic [CNT_W-1:0]   pos_q;
    pfx_t               pfx;
    opinfo_t            cls;
    logic [CNT_W-1:0]   cls_len;
    logic               take;
    logic               in_pfx_byte;
    logic               leaving;
    opsize_e            size_now;
    logic [8*IMM_BYTES-1:0] imm_raw;
    logic               rm_is_mem;
    logic [FIELD_W-1:0] reg_field;

    assign in_ready    = (st_q != ST_EMIT);
    assign take        = in_valid && in_ready;
    assign in_pfx_byte = is_prefix(in_data);
    assign leaving     = (st_q == ST_EMIT);
    assign cls         = classify(in_data);
    assign cls_len     = CNT_W'(imm_len(cls.form, pick_size(cls.byte_op, pfx)));

    atd_prefix_acc u_pfx (
        .clk   (clk),
        .rst   (rst),
        .clear (leaving),
        .load  (take && st_q == ST_PFX && in_pfx_byte),
        .data  (in_data),
        .pfx   (pfx)
    );

    atd_imm_gather #(.IMM_BYTES(IMM_BYTES)) u_imm (
        .clk   (clk),
        .rst   (rst),
        .clear (leaving),
        .load  (take && st_q == ST_IMM),
        .sel   (pos_q[SEL_W-1:0]),
        .data  (in_data),
        .value (imm_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_PFX;
            info_q  <= '0;
            modrm_q <= '0;
            nt_q    <= 1'b0;
            len_q   <= '0;
            pos_q   <= '0;
        end else begin
            case (st_q)
                ST_PFX: begin
                    if (take && !in_pfx_byte) begin
                        info_q <= cls;
                        len_q  <= cls_len;
                        pos_q  <= '0;
                        if (!cls.known) begin
                            nt_q <= 1'b1;
                            st_q <= ST_EMIT;
                        end else if (cls.has_modrm) begin
                            st_q <= ST_MODRM;
                        end else begin
                            st_q <= ST_IMM;
                        end
                    end
                end
                ST_MODRM: begin
                    if (take) begin
                        modrm_q <= in_data;
                        if (info_q.form == FORM_RM_IMM && in_data[5:4] != 2'b00) begin
                            nt_q <= 1'b1;
                            st_q <= ST_EMIT;
                        end else if (len_q == '0) begin
                            st_q <= ST_EMIT;
                        end else begin
                            st_q <= ST_IMM;
                        end
                    end
                end
                ST_IMM: begin
                    if (take) begin
                        pos_q <= pos_q + CNT_W'(1);
                        if (pos_q == len_q - CNT_W'(1)) st_q <= ST_EMIT;
                    end
                end
                default: begin
                    st_q    <= ST_PFX;
                    info_q  <= '0;
                    modrm_q <= '0;
                    nt_q    <= 1'b0;
                    len_q   <= '0;
                    pos_q   <= '0;
                end
            endcase
        end
    end

    assign size_now  = pick_size(info_q.byte_op, pfx);
    assign rm_is_mem = info_q.has_modrm && (modrm_q[7:6] != 2'b11);
    assign reg_field = (info_q.form == FORM_RM_REG) ? modrm_q[5:3] : '0;

    atd_reg_map #(.FIELD_W(FIELD_W)) u_rm_map (
        .field    (modrm_q[2:0]),
        .ext      (info_q.has_modrm && pfx.b),
        .rex_seen (pfx.rex_seen),
        .byte_op  (info_q.byte_op),
        .is_reg   (!rm_is_mem),
        .idx      (out_rm_idx),
        .hi       (out_rm_hi)
    );

    atd_reg_map #(.FIELD_W(FIELD_W)) u_reg_map (
        .field    (reg_field),
        .ext      ((info_q.form == FORM_RM_REG) && pfx.r),
        .rex_seen (pfx.rex_seen),
        .byte_op  (info_q.byte_op),
        .is_reg   (1'b1),
        .idx      (out_reg_idx),
        .hi       (out_reg_hi)
    );

    assign out_valid    = (st_q == ST_EMIT);
    assign out_size     = size_now;
    assign out_form     = info_q.form;
    assign out_rm_mem   = rm_is_mem;
    assign out_imm      = widen_imm(imm_raw[31:0], size_now);
    assign out_not_test = nt_q;
    assign out_fault_ud = out_valid && pfx.lock && !nt_q;
endmodule

// File: rtl/atd_checker.sv
module atd_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic [1:0]       out_size,
    input logic [1:0]       out_form,
    input logic [IDX_W-1:0] out_rm_idx,
    input logic             out_rm_hi,
    input logic             out_rm_mem,
    input logic [IDX_W-1:0] out_reg_idx,
    input logic             out_reg_hi,
    input logic [63:0]      out_imm,
    input logic             out_not_test
);
    logic rec;
    assign rec = out_valid && !out_not_test;

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);                                        // R14
    AST_NO_TAKE_IN_EMIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);                                         // R14
    AST_READY_AFTER_EMIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> in_ready);                                          // R14
    AST_BYTE_IMM_NARROW: assert property (@(posedge clk) disable iff (rst)
        (rec && out_size == 2'd0) |-> out_imm[63:8] == 56'd0);            // R6
    AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (rec && out_size == 2'd3) |-> out_imm[63:32] == {32{out_imm[31]}}); // R6
    AST_HI_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (rec && (out_rm_hi || out_reg_hi)) |-> out_size == 2'd0);         // R11
    AST_MEM_NOT_HI: assert property (@(posedge clk) disable iff (rst)
        (rec && out_rm_mem) |-> !out_rm_hi);                              // R10
    AST_ACC_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rec && out_form == 2'd0) |-> (out_rm_idx == '0 && !out_rm_mem)); // R3
    AST_RMI_NO_REG: assert property (@(posedge clk) disable iff (rst)
        (rec && out_form == 2'd1) |-> (out_reg_idx == '0 && !out_reg_hi)); // R7
    AST_RMR_NO_IMM: assert property (@(posedge clk) disable iff (rst)
        (rec && out_form == 2'd2) |-> out_imm == 64'd0);                  // R9
endmodule

bind andtest_decode atd_checker #(.IDX_W(IDX_W)) u_atd_checker (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_size     (out_size),
    .out_form     (out_form),
    .out_rm_idx   (out_rm_idx),
    .out_rm_hi    (out_rm_hi),
    .out_rm_mem   (out_rm_mem),
    .out_reg_idx  (out_reg_idx),
    .out_reg_hi   (out_reg_hi),
    .out_imm      (out_imm),
    .out_not_test (out_not_test)
);

// File: tb/test_andtest_decode.sv
module test_andtest_decode;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        out_valid;
    logic [1:0]  out_size;
    logic [1:0]  out_form;
    logic [3:0]  out_rm_idx;
    logic        out_rm_hi;
    logic        out_rm_mem;
    logic [3:0]  out_reg_idx;
    logic        out_reg_hi;
    logic [63:0] out_imm;
    logic        out_fault_ud;
    logic        out_not_test;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] seq [0:15];
    int nseq;

    always #2 clk = ~clk;

    andtest_decode i_andtest_decode (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_size(out_size),
        .out_form(out_form), .out_rm_idx(out_rm_idx), .out_rm_hi(out_rm_hi),
        .out_rm_mem(out_rm_mem), .out_reg_idx(out_reg_idx),
        .out_reg_hi(out_reg_hi), .out_imm(out_imm),
        .out_fault_ud(out_fault_ud), .out_not_test(out_not_test)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        seq[nseq] = b;
        nseq++;
    endtask

    // Drive queued bytes, then stop at the record cycle for sampling.
    task automatic play(input int gap);
        logic early;
        early = 1'b0;
        for (int i = 0; i < nseq; i++) begin
            @(negedge clk);
            if (gap > 0 && i > 0) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            if (out_valid) early = 1'b1;
            in_valid = 1'b1;
            in_data  = seq[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R14 no record before last byte", early, 1'b0);
        chk("R14 record strobe", out_valid, 1'b1);
        chk("R14 not ready in record cycle", in_ready, 1'b0);
    endtask

    task automatic map_reg(input logic [2:0] f, input logic ext, input logic rexp,
                           input logic bop, output logic [3:0] idx, output logic hi);
        if (bop && !rexp && f[2]) begin
            idx = {2'b00, f[1:0]};
            hi  = 1'b1;
        end else begin
            idx = {ext, f};
            hi  = 1'b0;
        end
    endtask

    task automatic run_case(input logic [7:0] op, input logic p66, input logic lock,
                            input int rexv, input logic [7:0] modrm,
                            input logic [31:0] imm, input int gap);
        logic bop, has_m, rexp, w, r, b, bad, mem;
        logic [1:0] form, size;
        int ilen;
        logic [3:0] e_rm, e_reg;
        logic e_rmhi, e_reghi;
        logic [63:0] e_imm;
        bop   = (op == 8'hA8) || (op == 8'hF6) || (op == 8'h84);
        has_m = (op != 8'hA8) && (op != 8'hA9);
        form  = (op == 8'hA8 || op == 8'hA9) ? 2'd0 :
                (op == 8'hF6 || op == 8'hF7) ? 2'd1 : 2'd2;
        rexp  = (rexv >= 0);
        w = rexp && rexv[3];
        r = rexp && rexv[2];
        b = rexp && rexv[0];
        size = bop ? 2'd0 : (w ? 2'd3 : (p66 ? 2'd1 : 2'd2));
        bad  = (form == 2'd1) && (modrm[5:3] >= 3'd2);
        ilen = (form == 2'd2) ? 0 : (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        nseq = 0;
        if (lock) push(8'hF0);
        if (p66)  push(8'h66);
        if (rexp) push(8'(rexv));
        push(op);
        if (has_m) push(modrm);
        if (!bad) for (int k = 0; k < ilen; k++) push(imm[8*k +: 8]);
        play(gap);
        chk("R8 not-this flag", out_not_test, bad);
        if (bad) begin
            chk("R8 no fault on rejected form", out_fault_ud, 1'b0);
        end else begin
            mem = has_m && (modrm[7:6] != 2'b11);
            if (!has_m) begin
                e_rm = 4'd0; e_rmhi = 1'b0;
            end else if (mem) begin
                e_rm = {b, modrm[2:0]}; e_rmhi = 1'b0;
            end else begin
                map_reg(modrm[2:0], b, rexp, bop, e_rm, e_rmhi);
            end
            if (form == 2'd2) map_reg(modrm[5:3], r, rexp, bop, e_reg, e_reghi);
            else begin e_reg = 4'd0; e_reghi = 1'b0; end
            case (size)
                2'd0: e_imm = {56'd0, imm[7:0]};
                2'd1: e_imm = {48'd0, imm[15:0]};
                2'd2: e_imm = {32'd0, imm};
                default: e_imm = {{32{imm[31]}}, imm};
            endcase
            if (form == 2'd2) e_imm = 64'd0;
            chk("R4 size code", out_size, size);
            if (form == 2'd0)      chk("R3 form code", out_form, form);
            else if (form == 2'd1) chk("R7 form code", out_form, form);
            else                   chk("R9 form code", out_form, form);
            chk("R10 memory flag", out_rm_mem, mem);
            chk("R11 rm index", out_rm_idx, e_rm);
            chk("R11 rm hi", out_rm_hi, e_rmhi);
            chk("R9 reg index", out_reg_idx, e_reg);
            chk("R11 reg hi", out_reg_hi, e_reghi);
            chk("R5 R6 immediate", out_imm, e_imm);
            chk("R12 fault", out_fault_ud, lock);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int rtab [0:4];
        logic [7:0] rm_ops [0:3];
        logic [7:0] mr;
        rtab[0] = -1; rtab[1] = 'h40; rtab[2] = 'h45; rtab[3] = 'h4A; rtab[4] = 'h4F;
        rm_ops[0] = 8'hF6; rm_ops[1] = 8'hF7; rm_ops[2] = 8'h84; rm_ops[3] = 8'h85;
        rst = 1'b1; in_valid = 1'b0; in_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", out_valid, 1'b0);
        chk("R1 reset ready", in_ready, 1'b1);

        // R3 accumulator forms under all prefix combinations
        for (int op = 0; op < 2; op++)
            for (int p = 0; p < 2; p++)
                for (int lk = 0; lk < 2; lk++)
                    for (int rx = -1; rx < 16; rx++)
                        run_case(op == 0 ? 8'hA8 : 8'hA9, p[0], lk[0],
                                 rx < 0 ? -1 : ('h40 + rx),
                                 8'h00, 32'h8000_0001 ^ (32'(rx + 1) * 32'h0101_0127), p);

        // R7 R8 R9 R10 R11 ModRM forms, every ModRM value
        for (int o = 0; o < 4; o++)
            for (int p = 0; p < 2; p++)
                for (int ri = 0; ri < 5; ri++)
                    for (int m = 0; m < 256; m++) begin
                        mr = 8'(m);
                        run_case(rm_ops[o], p[0], 1'b0, rtab[ri], mr,
                                 {mr ^ 8'hA5, mr + 8'd3, ~mr, mr}, (m % 37 == 0) ? 1 : 0);
                    end

        // R12 lock on ModRM forms
        for (int o = 0; o < 4; o++)
            run_case(rm_ops[o], 1'b1, 1'b1, 'h4D, 8'hC9, 32'hF00D_BEEF, 0);

        // R2 extension prefix before size override: W still wins, four imm bytes
        nseq = 0;
        push(8'h48); push(8'h66); push(8'h66); push(8'hA9);
        push(8'h11); push(8'h22); push(8'h33); push(8'h84);
        play(0);
        chk("R2 order-free prefixes size", out_size, 2'd3);
        chk("R2 order-free prefixes imm", out_imm, 64'hFFFF_FFFF_8433_2211);

        // R13 every non-prefix, non-family opcode
        for (int v = 0; v < 256; v++) begin
            if (v == 'h66 || v == 'hF0 || (v >= 'h40 && v <= 'h4F) || v == 'hA8 ||
                v == 'hA9 || v == 'hF6 || v == 'hF7 || v == 'h84 || v == 'h85) continue;
            nseq = 0;
            if (v % 2 == 1) push(8'hF0);
            push(8'(v));
            play(0);
            chk("R13 unknown opcode flag", out_not_test, 1'b1);
            chk("R13 unknown opcode no fault", out_fault_ud, 1'b0);
        end

        // R14 a byte offered in the record cycle is not taken; prefixes cleared
        nseq = 0;
        push(8'hF0); push(8'h66); push(8'hA8); push(8'h5A);
        play(0);
        chk("R14 lock seen first", out_fault_ud, 1'b1);
        in_valid = 1'b1;
        in_data  = 8'hF0;
        @(negedge clk);
        chk("R14 strobe drops", out_valid, 1'b0);
        in_data = 8'hA9;
        @(negedge clk);
        in_data = 8'h01;
        @(negedge clk); in_data = 8'h02;
        @(negedge clk); in_data = 8'h03;
        @(negedge clk); in_data = 8'h04;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R14 next record strobe", out_valid, 1'b1);
        chk("R14 stray lock not taken", out_fault_ud, 1'b0);
        chk("R14 size override cleared", out_size, 2'd2);
        chk("R14 imm of next record", out_imm, 64'h0000_0000_0403_0201);
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule